// File: doc/BRIEF.md
# Page Write Buffer Controller

This block gathers the data bytes of one page-write transaction and commits them to a byte-wide storage array in a single timed internal write cycle. A transaction starts with a start-address load, which selects a page and a starting position inside it. Data bytes then arrive over a valid/ready stream. Each accepted byte lands at the current in-page position, and that position then advances, wrapping inside the page. The storage array is not touched until an end-of-transaction (stop) event arrives. The stop copies only the positions written in this transaction into the array and starts a busy period of fixed length. During that period all new requests are ignored.

After reset, the block first fills the whole array with 0xFF, one location per clock, and reports busy while it does so. A plain read port serves lookups when the block is idle. Every commit write is also shown on a monitor port, so the surrounding logic can watch the array being updated. The stream rule is simple: a byte transfers on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` falls while the block is busy, when no start address has been loaded, and in any cycle where a stop or an address load is presented, so the sender must hold its byte until ready returns.

Top module: `pwb_ctrl`

## Requirements
- R1: After reset is released, `busy` stays high for exactly 2^ADDR_W cycles while every array location is set to 0xFF. Afterwards, every address reads back 0xFF.
- R2: An address load presented while idle does four things: it selects the page from `load_addr[ADDR_W-1:4]` and the start position from `load_addr[3:0]`, opens a session, and discards any bytes buffered earlier. A reload before the stop therefore leaves only the bytes written after it to be committed.
- R3: `wr_ready` is high only when all of these hold: the block is idle, a session is open, and neither `stop` nor `load_valid` is high. Each transferred byte goes to the current position. The position then increments modulo 16 while the page stays fixed.
- R4: If more than 16 bytes are sent in one session, the position wraps to the page start. The array receives, for each position, the last byte written there.
- R5: No array location changes before the stop. On the stop, only the positions written in this session are committed, and the other bytes of the page keep their old values.
- R6: A stop presented while idle, with at least one byte written in the session, raises `busy` from the next cycle for exactly WR_CYCLES cycles and closes the session.
- R7: A stop with no byte written since the last load (or with no session open) does not raise `busy`, writes nothing, and closes the session.
- R8: While `busy` is high, address loads, stops and reads are ignored: a read gives no `rd_valid`, and a load opens no session.
- R9: A read requested while idle returns `rd_data` with `rd_valid` high in the next cycle.
- R10: `commit_we` pulses only while `busy` is high, and only with an address inside the loaded page. There is one pulse per distinct position written in the session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Start-address load strobe |
| load_addr | input | ADDR_W | Start address: page in the upper bits, position in the lower 4 bits |
| wr_valid | input | 1 | Data byte valid |
| wr_ready | output | 1 | Data byte ready |
| wr_data | input | 8 | Data byte |
| stop | input | 1 | End-of-transaction event |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read data valid (one cycle after the request) |
| rd_data | output | 8 | Read data |
| commit_we | output | 1 | Commit write strobe to the array |
| commit_addr | output | ADDR_W | Commit write address |
| commit_data | output | 8 | Commit write data |
| busy | output | 1 | Erase or write cycle in progress |

## Verification
The bench sweeps every page of a 64-byte array. Each page is tried with start positions 0, 5 and 15 and with burst lengths of 1, 7, 16 and 20 bytes. The 1-byte burst shows that neighbouring bytes are preserved. The 16-byte burst from a mid-page start shows that the position wraps without carrying into the page bits. The 20-byte burst shows that overwriting follows last-writer order. A stop with no bytes, loads and reads issued during busy, and a reload partway through a session separate R7, R8 and R2 from the normal commit path, while the counted busy length and commit pulses pin R6 and R10.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    PH_ERASE  = 2'd0,
    PH_IDLE   = 2'd1,
    PH_COMMIT = 2'd2
  } phase_t;

  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer
  import pwb_pkg::*;
#(
  parameter int unsigned DEPTH     = 256,
  parameter int unsigned WR_CYCLES = 500000,
  parameter int unsigned CNT_W     = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             erasing,
  output logic             committing,
  output logic             done,
  output logic [CNT_W-1:0] idx
);

  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] WR_LAST    = CNT_W'(WR_CYCLES - 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_ERASE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_ERASE: begin
          if (cnt == ERASE_LAST) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_IDLE: begin
          if (start) begin
            phase <= PH_COMMIT;
            cnt   <= '0;
          end
        end
        PH_COMMIT: begin
          if (cnt == WR_LAST) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign erasing    = (phase == PH_ERASE);
  assign committing = (phase == PH_COMMIT);
  assign busy       = (phase != PH_IDLE);
  assign done       = committing && (cnt == WR_LAST);
  assign idx        = cnt;

endmodule

// File: rtl/pwb_page_buf.sv
module pwb_page_buf
  import pwb_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned OFF_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OFF_W-1:0]  load_off,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              flush,
  input  logic [OFF_W-1:0]  sel,
  output logic              any_valid,
  output logic              sel_valid,
  output logic [BYTE_W-1:0] sel_data
);

  logic [OFF_W-1:0]      off;
  logic [PAGE_BYTES-1:0] vmask;
  logic [BYTE_W-1:0]     slot [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off <= '0;
    end else if (load) begin
      off <= load_off;
    end else if (push) begin
      off <= off + 1'b1;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vmask[g] <= 1'b0;
        slot[g]  <= '0;
      end else if (load || flush) begin
        vmask[g] <= 1'b0;
      end else if (push && (off == OFF_W'(g))) begin
        vmask[g] <= 1'b1;
        slot[g]  <= push_data;
      end
    end
  end

  assign any_valid = |vmask;
  assign sel_valid = vmask[sel];
  assign sel_data  = slot[sel];

endmodule

// File: rtl/pwb_store.sv
module pwb_store
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rvalid,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= re;
      if (re) begin
        rdata <= mem[raddr];
      end
    end
  end

endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned WR_CYCLES  = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  input  logic              stop,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              commit_we,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [7:0]        commit_data,
  output logic              busy
);

  localparam int unsigned OFF_W   = $clog2(PAGE_BYTES);
  localparam int unsigned PAGE_W  = ADDR_W - OFF_W;
  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam int unsigned CNT_MAX = (DEPTH > WR_CYCLES) ? DEPTH : WR_CYCLES;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic              erasing, committing, done, start;
  logic [CNT_W-1:0]  idx;
  logic              load_acc, stop_acc, push;
  logic              open_q;
  logic [PAGE_W-1:0] page_q;
  logic              any_valid, sel_valid;
  logic [7:0]        sel_data;
  logic [OFF_W-1:0]  sel;
  logic              in_window;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [7:0]        ram_wdata;

  assign load_acc = load_valid && !busy && !stop;
  assign stop_acc = stop && !busy;
  assign start    = stop_acc && any_valid;
  assign wr_ready = !busy && open_q && !stop && !load_valid;
  assign push     = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      page_q <= '0;
    end else if (stop_acc) begin
      open_q <= 1'b0;
    end else if (load_acc) begin
      open_q <= 1'b1;
      page_q <= load_addr[ADDR_W-1:OFF_W];
    end
  end

  pwb_cycle_timer #(
    .DEPTH    (DEPTH),
    .WR_CYCLES(WR_CYCLES),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .erasing   (erasing),
    .committing(committing),
    .done      (done),
    .idx       (idx)
  );

  assign sel       = idx[OFF_W-1:0];
  assign in_window = (idx < CNT_W'(PAGE_BYTES));

  pwb_page_buf #(
    .PAGE_BYTES(PAGE_BYTES),
    .OFF_W     (OFF_W)
  ) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_acc),
    .load_off (load_addr[OFF_W-1:0]),
    .push     (push),
    .push_data(wr_data),
    .flush    (done),
    .sel      (sel),
    .any_valid(any_valid),
    .sel_valid(sel_valid),
    .sel_data (sel_data)
  );

  assign commit_we   = committing && in_window && sel_valid;
  assign commit_addr = {page_q, sel};
  assign commit_data = sel_data;

  assign ram_we    = erasing || commit_we;
  assign ram_waddr = erasing ? idx[ADDR_W-1:0] : commit_addr;
  assign ram_wdata = erasing ? ERASED_BYTE : commit_data;

  pwb_store #(
    .ADDR_W(ADDR_W),
    .DEPTH (DEPTH)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (rd_en && !busy),
    .raddr (rd_addr),
    .rvalid(rd_valid),
    .rdata (rd_data)
  );

endmodule

// File: rtl/pwb_ctrl_chk.sv
module pwb_ctrl_chk #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned WR_CYCLES  = 500000,
  parameter int unsigned PAGE_W     = ADDR_W - $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_valid,
  input logic [PAGE_W-1:0] load_page,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              stop,
  input logic              rd_en,
  input logic              rd_valid,
  input logic              commit_we,
  input logic [PAGE_W-1:0] commit_page,
  input logic              busy
);

  logic [7:0]        acc_cnt;
  logic [PAGE_W-1:0] page_seen;
  logic              busy_q, kind_q;
  logic [31:0]       run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt   <= '0;
      page_seen <= '0;
      busy_q    <= 1'b0;
      kind_q    <= 1'b0;
      run_q     <= '0;
    end else begin
      busy_q <= busy;
      run_q  <= busy ? run_q + 1 : '0;
      if (stop && !busy) begin
        acc_cnt <= '0;
      end else if (load_valid && !busy) begin
        acc_cnt   <= '0;
        page_seen <= load_page;
      end else if (wr_valid && wr_ready && acc_cnt != 8'hFF) begin
        acc_cnt <= acc_cnt + 1'b1;
      end
      if (stop && !busy && acc_cnt != 0) kind_q <= 1'b1;
      else if (busy_q && !busy)          kind_q <= 1'b0;
    end
  end

  p_ready_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);

  p_commit_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !busy && acc_cnt != 0) |=> busy);

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !busy && kind_q) |-> (run_q == WR_CYCLES));

  p_empty_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !busy && acc_cnt == 0) |=> !busy);

  p_read_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> !rd_valid);

  p_read_served_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy) |=> rd_valid);

  p_commit_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_we |-> busy);

  p_commit_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_we |-> (commit_page == page_seen));

endmodule

bind pwb_ctrl pwb_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .PAGE_BYTES(PAGE_BYTES),
  .WR_CYCLES (WR_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_valid (load_valid),
  .load_page  (load_addr[ADDR_W-1:$clog2(PAGE_BYTES)]),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .stop       (stop),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .commit_we  (commit_we),
  .commit_page(commit_addr[ADDR_W-1:$clog2(PAGE_BYTES)]),
  .busy       (busy)
);

// File: tb/pwb_ctrl_tb.sv
module pwb_ctrl_tb;

  localparam int AW    = 6;
  localparam int PB    = 16;
  localparam int WRC   = 24;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_valid = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [7:0]    wr_data = '0;
  logic          stop = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_valid;
  logic [7:0]    rd_data;
  logic          commit_we;
  logic [AW-1:0] commit_addr;
  logic [7:0]    commit_data;
  logic          busy;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [DEPTH];

  always #5 clk = ~clk;

  pwb_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_addr(load_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .stop(stop),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .commit_we(commit_we), .commit_addr(commit_addr), .commit_data(commit_data),
    .busy(busy));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [AW-1:0] a);
    @(negedge clk); load_valid = 1'b1; load_addr = a;
    @(negedge clk); load_valid = 1'b0;
  endtask

  task automatic do_push(input logic [7:0] d);
    @(negedge clk);
    check(wr_ready == 1'b1, "R3 ready in session", int'(wr_ready), 1);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic do_stop(output int blen, output int pulses);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    blen = 0; pulses = 0;
    while (busy && blen < 1000) begin
      blen++;
      if (commit_we) pulses++;
      @(negedge clk);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic v, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; v = rd_valid; d = rd_data;
  endtask

  task automatic verify_page(input int p, input string req);
    logic v; logic [7:0] d;
    for (int k = 0; k < PB; k++) begin
      do_read(AW'(p * PB + k), v, d);
      check(v && d == model[p * PB + k], req, int'(d), int'(model[p * PB + k]));
    end
  endtask

  function automatic logic [7:0] pattern(input int p, input int s, input int n, input int i);
    return 8'((p * 37 + s * 11 + n * 5 + i * 13) ^ 8'h5A);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int blen, pulses, cnt;
    logic v; logic [7:0] d;
    int starts [3] = '{0, 5, 15};
    int lens   [4] = '{1, 7, 16, 20};

    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R1 busy in reset", int'(busy), 1);
    check(wr_ready == 1'b0, "R3 no ready in reset", int'(wr_ready), 0);
    check(rd_valid == 1'b0, "R9 no read in reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    cnt = 0;
    while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
    check(cnt == DEPTH, "R1 erase length", cnt, DEPTH);
    check(wr_ready == 1'b0, "R3 no session before load", int'(wr_ready), 0);
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = 8'hFF;
      do_read(AW'(a), v, d);
      check(v && d == 8'hFF, "R1 R9 erased read", int'(d), 8'hFF);
    end

    // main sweep: page x start position x burst length
    for (int p = 0; p < DEPTH / PB; p++) begin
      for (int si = 0; si < 3; si++) begin
        for (int ni = 0; ni < 4; ni++) begin
          int s = starts[si];
          int n = lens[ni];
          do_load(AW'(p * PB + s));
          for (int i = 0; i < n; i++) do_push(pattern(p, s, n, i));
          do_read(AW'(p * PB + s), v, d);
          check(v && d == model[p * PB + s], "R5 no write before stop", int'(d), int'(model[p * PB + s]));
          do_stop(blen, pulses);
          check(blen == WRC, "R6 busy length", blen, WRC);
          check(pulses == ((n > PB) ? PB : n), "R10 commit pulse count", pulses, (n > PB) ? PB : n);
          check(wr_ready == 1'b0, "R6 session closed", int'(wr_ready), 0);
          for (int i = 0; i < n; i++) model[p * PB + ((s + i) % PB)] = pattern(p, s, n, i);
          verify_page(p, "R4 R5 page contents");
        end
      end
    end

    // R7: stop with no bytes
    do_load(AW'(8'h23));
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(busy == 1'b0, "R7 empty stop stays idle", int'(busy), 0);
      @(negedge clk);
    end
    check(wr_ready == 1'b0, "R7 session closed", int'(wr_ready), 0);
    verify_page(2, "R7 page unchanged");

    // R8: requests during busy
    do_load(AW'(8'h10));
    do_push(8'hC3);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    check(busy == 1'b1, "R8 busy after stop", int'(busy), 1);
    check(wr_ready == 1'b0, "R8 no ready while busy", int'(wr_ready), 0);
    load_valid = 1'b1; load_addr = AW'(8'h30); rd_en = 1'b1; rd_addr = '0;
    @(negedge clk); load_valid = 1'b0; rd_en = 1'b0;
    check(rd_valid == 1'b0, "R8 read ignored while busy", int'(rd_valid), 0);
    while (busy) @(negedge clk);
    check(wr_ready == 1'b0, "R8 load ignored while busy", int'(wr_ready), 0);
    model[8'h10] = 8'hC3;
    verify_page(1, "R8 single byte commit");
    verify_page(3, "R8 ignored load wrote nothing");

    // R2: reload in mid-session discards earlier bytes
    do_load(AW'(8'h34));
    do_push(8'hA1); do_push(8'hA2); do_push(8'hA3);
    do_load(AW'(8'h39));
    do_push(8'hD1); do_push(8'hD2);
    do_stop(blen, pulses);
    check(pulses == 2, "R2 reload clears buffered bytes", pulses, 2);
    model[8'h39] = 8'hD1; model[8'h3A] = 8'hD2;
    verify_page(3, "R2 reload page contents");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule